// File: doc/BRIEF.md
# Sixteen-Bit Host DWORD Access Bridge

This bridge sits between a host bus and a register and FIFO space that is 32 bits wide. The host bus can be 16 or 32 bits wide. When `mode32` is high, every host strobe passes straight through as a full 32-bit access. When `mode32` is low, the host needs two half-word accesses for each 32-bit word. For a write, the bridge holds the first half and issues one 32-bit write strobe when the matching second half arrives. For a read, the bridge pops or latches the whole word on the first half. It then serves the other half from a holding register, so the word behind it is popped exactly once per pair.

The host may send the two halves in either order. Both halves must fall in the same aligned DWORD, meaning byte address bits 2 and up stay the same. The bridge detects an access that breaks the pair:

- A second write to the same half throws the pending word away.
- A second read of the same half clears the pair, and the next read starts fresh.
- A change of DWORD address, or a change from read to write (or back), drops the partial pair. The new access then opens a fresh pair.

A 32-bit swap setting decides which half-word each value of address bit 1 reaches. The swap applies only in 16-bit mode, and only when the setting is all ones.

The pair logic is a five-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | No pair is open. |
| `ST_WLO` | A write pair is open and the low half is held. |
| `ST_WHI` | A write pair is open and the high half is held. |
| `ST_RLO` | A read pair is open and the low half has been served. |
| `ST_RHI` | A read pair is open and the high half has been served. |

The transitions are these:

- **Start write:** from any state, to `ST_WLO` or `ST_WHI`. This happens for a 16-bit write from `ST_IDLE`, a write to a different DWORD, or a write while a read pair is open.
- **Start read:** from any state, to `ST_RLO` or `ST_RHI`. It is taken under the same conditions as start write, with the roles of read and write exchanged.
- **Complete:** to `ST_IDLE`. This is the other half, in the same DWORD, of the same kind of access.
- **Repeat:** to `ST_IDLE`. This is the same half, in the same DWORD, of the same kind of access.
- **Wide:** to `ST_IDLE`. This is any cycle with `mode32` high.

In every other case the machine holds its state.

Top module: `hword_bridge`

## Requirements
- R1: In 16-bit mode, a write pair to both halves of one DWORD gives exactly one `core_wr` pulse. The pulse comes in the cycle of the second write, with `core_addr` equal to that DWORD. `core_wdata[31:16]` carries the value written to the high half and `core_wdata[15:0]` the value written to the low half. The first write gives no pulse.
- R2: In 16-bit mode, the two halves of a write pair or a read pair are accepted in either order, low then high or high then low.
- R3: If the DWORD address (host address bits 2 and up) changes between the halves, the partial pair is abandoned. The new access starts a fresh pair: a write is held without a pulse, and a read pops again.
- R4: In 16-bit mode, a second write to the same half of the same DWORD gives no `core_wr`. It discards the held half together with the repeated data, so the next write starts a new pair.
- R5: In 16-bit mode, the first read of a pair pulses `core_rd_pop` in the same cycle and returns the selected half of `core_rdata`. The second read gives no pop and returns the other half of the word latched at the first read.
- R6: In 16-bit mode, a second read of the same half of the same DWORD gives no pop and clears the pair. The following read pops again as the first half of a new pair.
- R7: In 16-bit mode, `host_oe_hi` stays 0 and `host_rdata[31:16]` reads 0. `host_oe_lo` equals `host_rd`.
- R8: In 16-bit mode with `swap_cfg` = 0xFFFFFFFF, host address bit 1 = 0 selects the high half and bit 1 = 1 selects the low half. Any other `swap_cfg` value selects the default mapping, where bit 1 = 0 is the low half and bit 1 = 1 is the high half. The data always sits on `host_wdata[15:0]` or `host_rdata[15:0]`, with byte order unchanged inside the half.
- R9: In 32-bit mode, `swap_cfg` has no effect. Each `host_wr` gives a `core_wr` in the same cycle with `core_wdata` = `host_wdata`. Each `host_rd` gives a pop, with `host_rdata` = `core_rdata` and both output enables high.
- R10: A write arriving while a read pair is open, or a read arriving while a write pair is open, abandons the open pair. The new access starts a fresh pair, and the abandoned write is never issued.
- R11: After reset, no pair is open and no strobe is active. A half written before reset is forgotten, so a single 16-bit write after reset gives no `core_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode32 | input | 1 | 1 = 32-bit host bus, 0 = 16-bit host bus |
| swap_cfg | input | 32 | Word swap setting; all ones enables the swap in 16-bit mode |
| host_addr | input | AW-1 (7) | Host byte address, bits AW-1 down to 1 |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 32 | Host write data; only bits 15:0 are used in 16-bit mode |
| host_rdata | output | 32 | Host read data, valid in the cycle of `host_rd` |
| host_oe_lo | output | 1 | Output enable for data lines 15:0 |
| host_oe_hi | output | 1 | Output enable for data lines 31:16 |
| core_addr | output | AW-2 (6) | DWORD address of the current access |
| core_wr | output | 1 | 32-bit write strobe |
| core_wdata | output | 32 | 32-bit write data |
| core_rd_pop | output | 1 | Read or pop strobe for the 32-bit word |
| core_rdata | input | 32 | 32-bit word at `core_addr`, combinational |

## Verification
The hardest situations to reach from the ports are the broken pairs: a half repeated within the same DWORD, a DWORD change between halves, and a change of direction in the middle of a pair. In each case the only visible effect is a missing or an extra strobe one or two accesses later. The bench reaches them with short directed sequences that follow each broken pair with a legal completion. It then checks whether that completion issues a write, and whether it pops again. This is done after a sweep of every DWORD address, both half orders and three swap settings. One of those swap settings is all ones except one bit, to separate the exact match from a near miss.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WLO,
        ST_WHI,
        ST_RLO,
        ST_RHI
    } hwb_state_e;
endpackage

// File: rtl/hwb_lane_map.sv
module hwb_lane_map #(
    parameter int HW = 16
) (
    input  logic            mode32,
    input  logic [2*HW-1:0] swap_cfg,
    input  logic            addr_b1,
    output logic            hi_sel
);
    logic swap_on;

    // swap only on an exact all-ones setting, and only on the narrow bus
    assign swap_on = (&swap_cfg) & ~mode32;
    assign hi_sel  = addr_b1 ^ swap_on;
endmodule

// File: rtl/hwb_pair_fsm.sv
module hwb_pair_fsm
    import hwb_pkg::*;
#(
    parameter int DAW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode32,
    input  logic           wr,
    input  logic           rd,
    input  logic           hi_sel,
    input  logic [DAW-1:0] dw_addr,
    output logic           core_wr,
    output logic           core_pop,
    output logic           ld_lo,
    output logic           ld_hi,
    output logic           ld_hold,
    output logic           use_hold
);
    hwb_state_e     st_q, st_d;
    logic [DAW-1:0] pend_q;
    logic           ld_pend;
    logic           same_dw;

    assign same_dw = (dw_addr == pend_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pend_q <= '0;
        end else begin
            st_q <= st_d;
            if (ld_pend) pend_q <= dw_addr;
        end
    end

    always_comb begin
        st_d     = st_q;
        core_wr  = 1'b0;
        core_pop = 1'b0;
        ld_lo    = 1'b0;
        ld_hi    = 1'b0;
        ld_hold  = 1'b0;
        use_hold = 1'b0;
        ld_pend  = 1'b0;
        if (mode32) begin
            core_wr  = wr;
            core_pop = rd & ~wr;
            st_d     = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (wr) begin
                        ld_lo = ~hi_sel; ld_hi = hi_sel; ld_pend = 1'b1;
                        st_d  = hi_sel ? ST_WHI : ST_WLO;
                    end else if (rd) begin
                        core_pop = 1'b1; ld_hold = 1'b1; ld_pend = 1'b1;
                        st_d     = hi_sel ? ST_RHI : ST_RLO;
                    end
                end
                ST_WLO, ST_WHI: begin
                    if (wr && same_dw) begin
                        // complete when the other half arrives, drop on repeat
                        core_wr = (st_q == ST_WLO) ? hi_sel : ~hi_sel;
                        st_d    = ST_IDLE;
                    end else if (wr) begin
                        ld_lo = ~hi_sel; ld_hi = hi_sel; ld_pend = 1'b1;
                        st_d  = hi_sel ? ST_WHI : ST_WLO;
                    end else if (rd) begin
                        core_pop = 1'b1; ld_hold = 1'b1; ld_pend = 1'b1;
                        st_d     = hi_sel ? ST_RHI : ST_RLO;
                    end
                end
                ST_RLO, ST_RHI: begin
                    if (rd && !wr && same_dw) begin
                        // second half or repeat: never pops, always closes
                        use_hold = 1'b1;
                        st_d     = ST_IDLE;
                    end else if (wr) begin
                        ld_lo = ~hi_sel; ld_hi = hi_sel; ld_pend = 1'b1;
                        st_d  = hi_sel ? ST_WHI : ST_WLO;
                    end else if (rd) begin
                        core_pop = 1'b1; ld_hold = 1'b1; ld_pend = 1'b1;
                        st_d     = hi_sel ? ST_RHI : ST_RLO;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    AST_WR_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr && !mode32) |-> (st_q == ST_WLO || st_q == ST_WHI)); // R1
    AST_WR_SAME_DWORD: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr && !mode32) |-> (dw_addr == pend_q)); // R3
    AST_REPEAT_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode32 && wr && same_dw && st_q == ST_WLO && !hi_sel) |-> !core_wr); // R4
    AST_SECOND_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode32 && rd && !wr && same_dw && (st_q == ST_RLO || st_q == ST_RHI)) |-> !core_pop); // R5
    AST_PAIR_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr && !mode32) |=> (st_q == ST_IDLE)); // R1
endmodule

// File: rtl/hwb_data.sv
module hwb_data #(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode32,
    input  logic            rd,
    input  logic            hi_sel,
    input  logic            ld_lo,
    input  logic            ld_hi,
    input  logic            ld_hold,
    input  logic            use_hold,
    input  logic [2*HW-1:0] host_wdata,
    input  logic [2*HW-1:0] core_rdata,
    output logic [2*HW-1:0] core_wdata,
    output logic [2*HW-1:0] host_rdata
);
    localparam int DW = 2 * HW;

    logic [DW-1:0] hold_q;
    logic [DW-1:0] src;
    logic [HW-1:0] half_out;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HW-1:0] wbuf_q;
        logic          ld_this;
        logic          cur_this;

        assign ld_this  = (h == 1) ? ld_hi : ld_lo;
        assign cur_this = (h == 1) ? hi_sel : ~hi_sel;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       wbuf_q <= '0;
            else if (ld_this) wbuf_q <= host_wdata[HW-1:0];
        end

        // the arriving half comes from the bus, the other from the buffer
        assign core_wdata[h*HW +: HW] = mode32   ? host_wdata[h*HW +: HW] :
                                        cur_this ? host_wdata[HW-1:0]     : wbuf_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hold_q <= '0;
        else if (ld_hold) hold_q <= core_rdata;
    end

    assign src      = use_hold ? hold_q : core_rdata;
    assign half_out = hi_sel ? src[DW-1:HW] : src[HW-1:0];

    always_comb begin
        if (!rd)         host_rdata = '0;
        else if (mode32) host_rdata = core_rdata;
        else             host_rdata = {{HW{1'b0}}, half_out};
    end
endmodule

// File: rtl/hword_bridge.sv
module hword_bridge #(
    parameter int AW = 8,
    parameter int HW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode32,
    input  logic [2*HW-1:0]   swap_cfg,
    input  logic [AW-1:1]     host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2*HW-1:0]   host_wdata,
    output logic [2*HW-1:0]   host_rdata,
    output logic              host_oe_lo,
    output logic              host_oe_hi,
    output logic [AW-3:0]     core_addr,
    output logic              core_wr,
    output logic [2*HW-1:0]   core_wdata,
    output logic              core_rd_pop,
    input  logic [2*HW-1:0]   core_rdata
);
    localparam int DW  = 2 * HW;
    localparam int DAW = AW - 2;

    logic hi_sel;
    logic ld_lo, ld_hi, ld_hold, use_hold;

    assign core_addr  = host_addr[AW-1:2];
    assign host_oe_lo = host_rd;
    assign host_oe_hi = host_rd & mode32;

    hwb_lane_map #(.HW(HW)) u_map (
        .mode32  (mode32),
        .swap_cfg(swap_cfg),
        .addr_b1 (host_addr[1]),
        .hi_sel  (hi_sel)
    );

    hwb_pair_fsm #(.DAW(DAW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode32  (mode32),
        .wr      (host_wr),
        .rd      (host_rd),
        .hi_sel  (hi_sel),
        .dw_addr (core_addr),
        .core_wr (core_wr),
        .core_pop(core_rd_pop),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .ld_hold (ld_hold),
        .use_hold(use_hold)
    );

    hwb_data #(.HW(HW)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode32    (mode32),
        .rd        (host_rd),
        .hi_sel    (hi_sel),
        .ld_lo     (ld_lo),
        .ld_hi     (ld_hi),
        .ld_hold   (ld_hold),
        .use_hold  (use_hold),
        .host_wdata(host_wdata),
        .core_rdata(core_rdata),
        .core_wdata(core_wdata),
        .host_rdata(host_rdata)
    );

    AST_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode32 |-> (host_rdata[DW-1:HW] == '0 && !host_oe_hi)); // R7
    AST_WR_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_wr && core_rd_pop)); // R10
    AST_WIDE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode32 && core_wr) |-> (core_wdata == host_wdata)); // R9
endmodule

// File: tb/hword_bridge_tb.sv
module hword_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int HW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode32 = 1'b0;
    logic [DW-1:0] swap_cfg = '0;
    logic [AW-1:1] host_addr = '0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_oe_lo, host_oe_hi;
    logic [AW-3:0] core_addr;
    logic          core_wr;
    logic [DW-1:0] core_wdata;
    logic          core_rd_pop;
    logic [DW-1:0] core_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    logic          s_wr, s_pop, s_oe_lo, s_oe_hi;
    logic [DW-1:0] s_wdata, s_rdata;
    logic [AW-3:0] s_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] rdpat(input logic [AW-3:0] d);
        return 32'h9E3779B9 * ({26'b0, d} + 32'd1);
    endfunction

    assign core_rdata = rdpat(core_addr);

    hword_bridge #(.AW(AW), .HW(HW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode32(mode32), .swap_cfg(swap_cfg),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_oe_lo(host_oe_lo), .host_oe_hi(host_oe_hi),
        .core_addr(core_addr), .core_wr(core_wr), .core_wdata(core_wdata),
        .core_rd_pop(core_rd_pop), .core_rdata(core_rdata)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic r, input logic [AW-3:0] dw,
                       input logic b1, input logic [DW-1:0] d);
        @(negedge clk);
        host_wr = w; host_rd = r; host_addr = {dw, b1}; host_wdata = d;
        #(CLK_PERIOD/4);
        s_wr = core_wr; s_pop = core_rd_pop; s_wdata = core_wdata;
        s_rdata = host_rdata; s_oe_lo = host_oe_lo; s_oe_hi = host_oe_hi;
        s_addr = core_addr;
        @(posedge clk);
        #1;
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    function automatic logic [HW-1:0] pick(input logic [DW-1:0] v, input logic hi);
        return hi ? v[DW-1:HW] : v[HW-1:0];
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [HW-1:0] lo, hi;
        logic          sw, h1;
        logic [DW-1:0] f;

        // R11: reset state
        #(CLK_PERIOD * 2 + 2);
        chk("R11 wr in reset", {31'b0, core_wr}, 32'd0);
        chk("R11 pop in reset", {31'b0, core_rd_pop}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // sweep: swap setting x DWORD x order
        for (int sc = 0; sc < 3; sc++) begin
            swap_cfg = (sc == 0) ? 32'h0 : (sc == 1) ? 32'hFFFF_FFFF : 32'hFFFF_FFFE;
            sw = (sc == 1);
            for (int dw = 0; dw < 64; dw++) begin
                for (int ord = 0; ord < 2; ord++) begin
                    lo = 16'(dw * 317 + ord * 11 + sc * 5003);
                    hi = 16'(dw * 40503 + 16'h1234 + ord);
                    h1 = ord[0] ^ sw;
                    acc(1, 0, 6'(dw), ord[0], {16'h0, h1 ? hi : lo});
                    chk("R1 first write no strobe", {31'b0, s_wr}, 32'd0);
                    acc(1, 0, 6'(dw), ~ord[0], {16'h0, h1 ? lo : hi});
                    chk("R2 second write strobe", {31'b0, s_wr}, 32'd1);
                    chk("R8 write data mapping", s_wdata, {hi, lo});
                    chk("R1 write addr", {26'b0, s_addr}, 32'(dw));
                    f = rdpat(6'(dw));
                    acc(0, 1, 6'(dw), ord[0], '0);
                    chk("R5 first read pops", {31'b0, s_pop}, 32'd1);
                    chk("R8 first read data", s_rdata, {16'h0, pick(f, h1)});
                    chk("R7 oe", {30'b0, s_oe_hi, s_oe_lo}, 32'd1);
                    acc(0, 1, 6'(dw), ~ord[0], '0);
                    chk("R5 second read no pop", {31'b0, s_pop}, 32'd0);
                    chk("R2 second read data", s_rdata, {16'h0, pick(f, ~h1)});
                end
            end
        end

        swap_cfg = 32'h0;
        // R4: repeated write half
        acc(1, 0, 6'd5, 1'b0, 32'h0000_1111);
        acc(1, 0, 6'd5, 1'b0, 32'h0000_2222);
        chk("R4 repeat write no strobe", {31'b0, s_wr}, 32'd0);
        acc(1, 0, 6'd5, 1'b1, 32'h0000_3333);
        chk("R4 after repeat new pair", {31'b0, s_wr}, 32'd0);
        acc(1, 0, 6'd5, 1'b0, 32'h0000_4444);
        chk("R4 completion strobe", {31'b0, s_wr}, 32'd1);
        chk("R4 completion data", s_wdata, 32'h3333_4444);

        // R6: repeated read half
        f = rdpat(6'd7);
        acc(0, 1, 6'd7, 1'b0, '0);
        chk("R6 first pop", {31'b0, s_pop}, 32'd1);
        acc(0, 1, 6'd7, 1'b0, '0);
        chk("R6 repeat no pop", {31'b0, s_pop}, 32'd0);
        acc(0, 1, 6'd7, 1'b1, '0);
        chk("R6 restart pops", {31'b0, s_pop}, 32'd1);
        chk("R6 restart data", s_rdata, {16'h0, f[31:16]});
        acc(0, 1, 6'd7, 1'b0, '0);
        chk("R6 restart second no pop", {31'b0, s_pop}, 32'd0);
        chk("R6 restart second data", s_rdata, {16'h0, f[15:0]});

        // R3: DWORD change between halves
        acc(1, 0, 6'd9, 1'b0, 32'h0000_AAAA);
        acc(1, 0, 6'd10, 1'b1, 32'h0000_BBBB);
        chk("R3 addr change no strobe", {31'b0, s_wr}, 32'd0);
        acc(1, 0, 6'd10, 1'b0, 32'h0000_CCCC);
        chk("R3 fresh pair strobe", {31'b0, s_wr}, 32'd1);
        chk("R3 fresh pair data", s_wdata, 32'hBBBB_CCCC);
        chk("R3 fresh pair addr", {26'b0, s_addr}, 32'd10);
        acc(0, 1, 6'd11, 1'b0, '0);
        acc(0, 1, 6'd12, 1'b1, '0);
        chk("R3 read addr change pops", {31'b0, s_pop}, 32'd1);
        f = rdpat(6'd12);
        chk("R3 read addr change data", s_rdata, {16'h0, f[31:16]});

        // R10: direction change mid-pair
        acc(1, 0, 6'd3, 1'b0, 32'h0000_5555);
        acc(0, 1, 6'd3, 1'b1, '0);
        chk("R10 read after write pops", {31'b0, s_pop}, 32'd1);
        chk("R10 read after write no wr", {31'b0, s_wr}, 32'd0);
        acc(1, 0, 6'd3, 1'b1, 32'h0000_6666);
        chk("R10 write after read no wr", {31'b0, s_wr}, 32'd0);
        acc(1, 0, 6'd3, 1'b0, 32'h0000_7777);
        chk("R10 completion", {31'b0, s_wr}, 32'd1);
        chk("R10 completion data", s_wdata, 32'h6666_7777);

        // R9: 32-bit mode ignores swap
        mode32 = 1'b1;
        swap_cfg = 32'hFFFF_FFFF;
        acc(1, 0, 6'd20, 1'b0, 32'hCAFE_F00D);
        chk("R9 wide write strobe", {31'b0, s_wr}, 32'd1);
        chk("R9 wide write data", s_wdata, 32'hCAFE_F00D);
        acc(1, 0, 6'd20, 1'b0, 32'h1357_9BDF);
        chk("R9 wide repeat strobe", {31'b0, s_wr}, 32'd1);
        chk("R9 wide repeat data", s_wdata, 32'h1357_9BDF);
        acc(0, 1, 6'd20, 1'b1, '0);
        chk("R9 wide read pop", {31'b0, s_pop}, 32'd1);
        chk("R9 wide read data", s_rdata, rdpat(6'd20));
        chk("R9 wide oe", {30'b0, s_oe_hi, s_oe_lo}, 32'd3);
        mode32 = 1'b0;
        swap_cfg = 32'h0;

        // R11: a half held before reset is forgotten
        acc(1, 0, 6'd30, 1'b0, 32'h0000_0101);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        acc(1, 0, 6'd30, 1'b1, 32'h0000_0202);
        chk("R11 no strobe after reset", {31'b0, s_wr}, 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule